// File: doc/BRIEF.md
# Compare-and-Skip Program Counter Unit

This block holds the program counter of a single-accumulator machine whose instructions all occupy one word. On each cycle with `step` high it loads the address of the next instruction to run. Normally that is the current address plus one. The unit also adds zero, one or two extra words depending on the decoded instruction class, the accumulator and an operand. Fetch, the ALU and the register file sit outside it. The decoder supplies a 3-bit class and the instruction's address field. The memory path supplies an already-read operand for the memory form of the compare.

Branching comes from passing over words rather than from loading a target. An unconditional skip passes over one word. An accumulator test passes over one word when its selected condition holds. A compare gives a three-way transfer from a single signed comparison: the machine runs the next word when the accumulator is less than the operand, the one after that when they are equal, and the third word when it is greater. Placing two compares in a row gives a bounds check that reaches a fall-through instruction only when the accumulator is strictly between two limits. The pins are plain control pins, so there is no handshake. `step` acts as a qualifier, and while it is low the counter holds its value.

Top module: `pcu_skip_unit`

## Requirements
- R1: A synchronous active-high `rst` sets `pc` to 0 at the next rising clock edge.
- R2: While `step` is low, `pc` keeps its value, whatever the other inputs are.
- R3: With `step` high and class 0 (sequential), `pc` advances by 1.
- R4: With `step` high and class 1 (unconditional skip), `pc` advances by 2.
- R5: Class 2 (accumulator test) uses `addr_field[1:0]` to pick the condition: 0 is negative, 1 is nonzero, 2 is non-negative, 3 is zero. The advance is 2 when the condition holds and 1 when it does not. The higher address bits have no effect.
- R6: Class 3 (immediate compare) compares `acc` as signed against the sign-extended `addr_field`, and advances by 1 when less, 2 when equal and 3 when greater.
- R7: Class 4 (memory compare) does the same signed compare against `mem_operand`, and `addr_field` has no effect.
- R8: `pc` wraps modulo 2^ADDR_W when an advance crosses the top of the address space.
- R9: Class codes 5, 6 and 7 behave as sequential, with no extra advance.
- R10: `skip_amt` shows the extra advance (0, 1 or 2) for the current inputs, combinationally. A stepped cycle moves `pc` by exactly 1 plus that amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Update the counter this cycle |
| op_class | input | 3 | Decoded instruction class |
| addr_field | input | ADDR_W | Address field of the instruction (immediate or test code) |
| acc | input | DATA_W | Accumulator value |
| mem_operand | input | DATA_W | Operand read from memory for the memory compare |
| pc | output | ADDR_W | Current program counter |
| skip_amt | output | 2 | Extra words passed over by the current instruction |

## Verification
The assertions assume that the inputs are stable, known values around each rising edge. They also assume that `rst` is high from time zero until the first edges have gone by. The bench drives every input on the falling edge and holds reset over the first cycles, so both assumptions hold. The random stimulus draws class codes from all eight values, including the undefined ones. It draws operands from full-width random values, and it deliberately forces equality in a share of the compares so that the equal branch is exercised.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [2:0] {
    CLS_SEQ  = 3'd0,
    CLS_SKIP = 3'd1,
    CLS_TEST = 3'd2,
    CLS_CMPI = 3'd3,
    CLS_CMPM = 3'd4
  } pc_class_e;

  typedef enum logic [1:0] {
    TST_NEG    = 2'd0,
    TST_NZ     = 2'd1,
    TST_NONNEG = 2'd2,
    TST_ZERO   = 2'd3
  } acc_test_e;

  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
  } cmp_res_t;
endpackage

// File: rtl/pcu_operand_sel.sv
module pcu_operand_sel #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 12
) (
  input  logic [ADDR_W-1:0] addr_field,
  input  logic [DATA_W-1:0] mem_operand,
  input  logic              use_mem,
  output logic [DATA_W-1:0] operand
);
  logic [DATA_W-1:0] imm_ext;

  generate
    if (ADDR_W >= DATA_W) begin : g_trunc
      assign imm_ext = addr_field[DATA_W-1:0];
    end else begin : g_sext
      localparam int PAD_W = DATA_W - ADDR_W;
      assign imm_ext = {{PAD_W{addr_field[ADDR_W-1]}}, addr_field};
    end
  endgenerate

  assign operand = use_mem ? mem_operand : imm_ext;
endmodule

// File: rtl/pcu_signed_cmp.sv
module pcu_signed_cmp
  import pcu_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output cmp_res_t          res
);
  logic [DATA_W:0] diff;
  logic            sign_a;
  logic            sign_b;
  logic            less;

  assign sign_a = a[DATA_W-1];
  assign sign_b = b[DATA_W-1];
  assign diff   = {1'b0, a} - {1'b0, b};

  always_comb begin
    if (sign_a != sign_b) less = sign_a;
    else                  less = diff[DATA_W];
    res.eq = (a == b);
    res.lt = less;
    res.gt = !less && !res.eq;
  end
endmodule

// File: rtl/pcu_acc_test.sv
module pcu_acc_test
  import pcu_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0] acc,
  input  logic [1:0]        cond,
  output logic              hit
);
  logic is_neg;
  logic is_zero;

  assign is_neg  = acc[DATA_W-1];
  assign is_zero = (acc == '0);

  always_comb begin
    case (acc_test_e'(cond))
      TST_NEG:    hit = is_neg;
      TST_NZ:     hit = !is_zero;
      TST_NONNEG: hit = !is_neg;
      default:    hit = is_zero;
    endcase
  end
endmodule

// File: rtl/pcu_skip_unit.sv
module pcu_skip_unit
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [2:0]        op_class,
  input  logic [ADDR_W-1:0] addr_field,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] mem_operand,
  output logic [ADDR_W-1:0] pc,
  output logic [1:0]        skip_amt
);
  localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);

  logic [DATA_W-1:0] operand;
  cmp_res_t          cres;
  logic              test_hit;
  logic              use_mem;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_nxt;

  assign use_mem = (op_class == CLS_CMPM);

  pcu_operand_sel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_opsel (
    .addr_field (addr_field),
    .mem_operand(mem_operand),
    .use_mem    (use_mem),
    .operand    (operand)
  );

  pcu_signed_cmp #(.DATA_W(DATA_W)) u_cmp (
    .a  (acc),
    .b  (operand),
    .res(cres)
  );

  pcu_acc_test #(.DATA_W(DATA_W)) u_test (
    .acc (acc),
    .cond(addr_field[1:0]),
    .hit (test_hit)
  );

  // Compare: one extra word for ge, another for gt.
  always_comb begin
    case (op_class)
      CLS_SKIP:           skip_amt = 2'd1;
      CLS_TEST:           skip_amt = {1'b0, test_hit};
      CLS_CMPI, CLS_CMPM: skip_amt = {1'b0, !cres.lt} + {1'b0, cres.gt};
      default:            skip_amt = 2'd0;
    endcase
  end

  assign pc_nxt = pc_q + PC_ONE + ADDR_W'(skip_amt);

  always_ff @(posedge clk) begin
    if (rst)       pc_q <= '0;
    else if (step) pc_q <= pc_nxt;
  end

  assign pc = pc_q;
endmodule

// File: rtl/pcu_skip_unit_chk.sv
module pcu_skip_unit_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              step,
  input logic [2:0]        op_class,
  input logic [ADDR_W-1:0] addr_field,
  input logic [DATA_W-1:0] acc,
  input logic [DATA_W-1:0] mem_operand,
  input logic [ADDR_W-1:0] pc,
  input logic [1:0]        skip_amt
);
  p_reset_pc_r1: assert property (@(posedge clk) rst |=> pc == '0);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !step |=> pc == $past(pc));

  p_seq_adv_r3: assert property (@(posedge clk) disable iff (rst)
    step && op_class == 3'd0 |=> pc == ADDR_W'($past(pc) + ADDR_W'(1)));

  p_skip_adv_r4: assert property (@(posedge clk) disable iff (rst)
    step && op_class == 3'd1 |=> pc == ADDR_W'($past(pc) + ADDR_W'(2)));

  p_test_zero_r5: assert property (@(posedge clk) disable iff (rst)
    op_class == 3'd2 && addr_field[1:0] == 2'd3 && acc == '0 |-> skip_amt == 2'd1);

  p_test_neg_r5: assert property (@(posedge clk) disable iff (rst)
    op_class == 3'd2 && addr_field[1:0] == 2'd0 && !acc[DATA_W-1] |-> skip_amt == 2'd0);

  p_cmpm_eq_r7: assert property (@(posedge clk) disable iff (rst)
    op_class == 3'd4 && acc == mem_operand |-> skip_amt == 2'd1);

  p_cmpm_gt_r7: assert property (@(posedge clk) disable iff (rst)
    op_class == 3'd4 && $signed(acc) > $signed(mem_operand) |-> skip_amt == 2'd2);

  p_cmpm_lt_r6: assert property (@(posedge clk) disable iff (rst)
    op_class == 3'd4 && $signed(acc) < $signed(mem_operand) |-> skip_amt == 2'd0);

  p_undef_cls_r9: assert property (@(posedge clk) disable iff (rst)
    op_class >= 3'd5 |-> skip_amt == 2'd0);

  p_amt_range_r10: assert property (@(posedge clk) disable iff (rst)
    skip_amt != 2'd3);

  p_adv_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    step |=> pc == ADDR_W'($past(pc) + ADDR_W'(1) + ADDR_W'($past(skip_amt))));
endmodule

bind pcu_skip_unit pcu_skip_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .step       (step),
  .op_class   (op_class),
  .addr_field (addr_field),
  .acc        (acc),
  .mem_operand(mem_operand),
  .pc         (pc),
  .skip_amt   (skip_amt)
);

// File: tb/pcu_skip_unit_test.sv
module pcu_skip_unit_test;
  localparam int AW = 12;
  localparam int DW = 12;
  localparam int MAX_CYC = 150000;

  logic          clk = 1'b0;
  logic          rst;
  logic          step;
  logic [2:0]    op_class;
  logic [AW-1:0] addr_field;
  logic [DW-1:0] acc;
  logic [DW-1:0] mem_operand;
  logic [AW-1:0] pc;
  logic [1:0]    skip_amt;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [AW-1:0] model_pc;

  always #5 clk = ~clk;

  pcu_skip_unit #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .step(step), .op_class(op_class),
    .addr_field(addr_field), .acc(acc), .mem_operand(mem_operand),
    .pc(pc), .skip_amt(skip_amt)
  );

  function automatic logic [1:0] cmp3(input logic [DW-1:0] a, input logic [DW-1:0] b);
    if ($signed(a) < $signed(b)) return 2'd0;
    if (a == b) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [1:0] exp_amt(input logic [2:0] c, input logic [AW-1:0] ad,
                                         input logic [DW-1:0] a, input logic [DW-1:0] m);
    case (c)
      3'd1: return 2'd1;
      3'd2: case (ad[1:0])
              2'd0: return {1'b0, a[DW-1]};
              2'd1: return {1'b0, a != 0};
              2'd2: return {1'b0, !a[DW-1]};
              default: return {1'b0, a == 0};
            endcase
      3'd3: return cmp3(a, ad);
      3'd4: return cmp3(a, m);
      default: return 2'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_op(input string req, input logic s, input logic [2:0] c,
                       input logic [AW-1:0] ad, input logic [DW-1:0] a, input logic [DW-1:0] m);
    logic [1:0] e;
    @(negedge clk);
    step = s; op_class = c; addr_field = ad; acc = a; mem_operand = m;
    #1;
    e = exp_amt(c, ad, a, m);
    check({req, " skip_amt R10"}, AW'(skip_amt), AW'(e));
    if (s) model_pc = model_pc + AW'(1) + AW'(e);
    @(posedge clk); #1;
    check({req, " pc"}, pc, model_pc);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; step = 1'b0;
    @(posedge clk); #1;
    model_pc = '0;
    check("R1 reset", pc, '0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(MAX_CYC * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; step = 1'b0; op_class = '0; addr_field = '0; acc = '0; mem_operand = '0;
    model_pc = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state", pc, '0);
    do_reset();

    do_op("R3 seq", 1'b1, 3'd0, 12'h123, 12'h000, 12'h000);
    do_op("R4 skip", 1'b1, 3'd1, 12'h000, 12'h800, 12'h000);
    do_op("R2 hold", 1'b0, 3'd1, 12'h000, 12'h000, 12'h000);
    do_op("R5 neg hit", 1'b1, 3'd2, 12'hFF0, 12'h800, 12'h000);
    do_op("R5 neg miss", 1'b1, 3'd2, 12'h000, 12'h001, 12'h000);
    do_op("R5 nonzero", 1'b1, 3'd2, 12'h001, 12'h000, 12'h000);
    do_op("R5 nonneg", 1'b1, 3'd2, 12'h002, 12'h7FF, 12'h000);
    do_op("R5 zero", 1'b1, 3'd2, 12'hAB3, 12'h000, 12'h000);
    do_op("R6 imm lt", 1'b1, 3'd3, 12'hFFF, 12'h800, 12'h000);
    do_op("R6 imm eq", 1'b1, 3'd3, 12'h805, 12'h805, 12'h000);
    do_op("R6 imm gt", 1'b1, 3'd3, 12'h800, 12'h7FF, 12'h000);
    do_op("R7 mem eq", 1'b1, 3'd4, 12'h001, 12'h321, 12'h321);
    do_op("R7 mem gt", 1'b1, 3'd4, 12'h7FF, 12'h000, 12'hFFF);
    do_op("R9 undef", 1'b1, 3'd7, 12'h000, 12'h100, 12'h000);

    // R8: walk close to the top, then cross it with a greater compare.
    do_reset();
    for (int i = 0; i < 2047; i++) do_op("R4 walk", 1'b1, 3'd1, 12'h000, 12'h000, 12'h000);
    check("R8 near top", pc, 12'd4094);
    do_op("R8 wrap", 1'b1, 3'd3, 12'h000, 12'h005, 12'h000);
    check("R8 wrapped", pc, 12'd1);

    // R6 bounds idiom: compare upper, compare lower, branch, branch, fall-through.
    for (int k = 0; k < 7; k++) begin
      logic [DW-1:0] v;
      logic [AW-1:0] tgt;
      v = DW'(k * 5 - 5);
      do_reset();
      do_op("R6 bound upper", 1'b1, 3'd3, 12'd20, v, 12'h000);
      if (pc == 12'd1) do_op("R6 bound lower", 1'b1, 3'd3, 12'd5, v, 12'h000);
      tgt = ($signed(v) > 5 && $signed(v) < 20) ? 12'd4 : 12'd0;
      if (tgt == 12'd4) check("R6 bounds inside", pc, 12'd4);
      else begin
        checks++;
        if (!(pc == 12'd2 || pc == 12'd3)) begin
          errors++;
          $display("FAIL R6 bounds outside actual=%0d expected=2or3", pc);
        end
      end
    end

    do_reset();
    for (int i = 0; i < 1500; i++) begin
      logic [2:0] c;
      logic [AW-1:0] ad;
      logic [DW-1:0] a, m;
      c = 3'($urandom);
      ad = AW'($urandom);
      a = DW'($urandom);
      m = DW'($urandom);
      if ($urandom % 4 == 0) begin m = a; ad = a; end
      do_op("R3-random R2", ($urandom % 8) != 0, c, ad, a, m);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule